// File: doc/BRIEF.md
# Serial EEPROM Station Address Loader

This block reads a configuration image out of a three-wire serial EEPROM as soon as reset is released, and turns the first three words of that image into a 48-bit station address. It drives chip select, shift clock and serial data toward the memory. It takes the memory's serial data output back through a two-flop synchroniser. Every shift-clock level is held for a fixed number of system clocks, set by a parameter. That number must be at least 3 and should give a level of at least 1 microsecond.

The block does not know in advance how wide the memory's word address is. Its first access is therefore a trial read of word 0 with a 6-bit address. A result of all ones means the device expects more address bits, so every later access uses 8 bits; any other result keeps 6 bits. After the trial read it reads all 64 words in order and adds them modulo 2^16. The image is accepted only if that sum equals the signature 0xBABA. When the last word has been read, the block presents the address, a valid flag and a one-cycle done pulse, and it stays quiet until the next reset.

Top module: `eeprom_addr_loader`

## Requirements
- R1: While reset is high and on the first cycle after it, `rom_cs`, `rom_sk`, `station_addr`, `addr_valid` and `load_done` are all 0. This holds even if an earlier load produced a valid address.
- R2: Every access holds `rom_cs` low for at least one half-period and then raises it. The first bits shifted out, on rising `rom_sk` edges, are 1, 1, 0, followed by the word address MSB first. `rom_di` changes only while `rom_sk` is low.
- R3: After the address, 16 rising `rom_sk` edges clock in the data word MSB first. Each bit is sampled while `rom_sk` is high. `rom_sk` is never high while `rom_cs` is low, and `rom_cs` returns low at the end of each access.
- R4: The first access reads word 0 with a 6-bit address. If it returns 0xFFFF, all later accesses use an 8-bit address; otherwise they use a 6-bit address.
- R5: After the trial read, words 0 to 63 are read once each in increasing order, so one load makes exactly 65 accesses.
- R6: `addr_valid` is 1 exactly when the sum modulo 2^16 of words 0 to 63 equals 0xBABA.
- R7: When valid, `station_addr[47:40]` is word 0 bits 7:0 and `[39:32]` is word 0 bits 15:8. `[31:24]` and `[23:16]` are the low and high bytes of word 1, and `[15:8]` and `[7:0]` are the low and high bytes of word 2. When not valid, `station_addr` is 0.
- R8: Each high and each low level of `rom_sk` lasts at least HALF_CLKS system clocks.
- R9: `load_done` is high for exactly one cycle, in the same cycle that the final `station_addr` and `addr_valid` appear. After that no further access starts and the outputs hold until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; a load starts when it is released |
| rom_cs | output | 1 | Chip select to the EEPROM |
| rom_sk | output | 1 | Shift clock to the EEPROM |
| rom_di | output | 1 | Serial command and address toward the EEPROM |
| rom_do | input | 1 | Serial data from the EEPROM |
| station_addr | output | 48 | Station address, first byte in bits 47:40 |
| addr_valid | output | 1 | Image signature matched |
| load_done | output | 1 | One-cycle pulse when the load completes |

## Verification
The bench models the memory at the serial pins and runs it in two modes: a 6-bit-address device and an 8-bit-address device. For the 8-bit device, word 0 is chosen so that the too-short trial read returns all ones. A wrong address-width decision then shows up as wrong word addresses seen by the model, wrong data and a failed checksum, so it cannot pass silently. Each device mode is loaded once with an image whose sum hits the signature and once with an image that misses it by one. This separates byte ordering and word capture, which only the valid images can show, from zero-forcing of the address, which only the bad images can show. Pin timing is checked throughout: the model counts opcode and address errors, data-in changes while the clock is high, and clock levels shorter than the half-period. After each load the bench waits and confirms that no further access starts.

// File: rtl/eeld_pkg.sv
package eeld_pkg;
  // bits of the read command (start bit included), shifted out first
  localparam int        OPW      = 3;
  localparam logic [OPW-1:0] READ_OP = 3'b110;
  localparam int        WORD_W   = 16;
  // station address is built from this many leading image words
  localparam int        ADDR_WORDS = 3;
  localparam int        STATION_W  = WORD_W * ADDR_WORDS;

  typedef enum logic [2:0] {
    PH_IDLE, PH_DESEL, PH_CLO, PH_CHI, PH_DLO, PH_DHI, PH_END
  } phase_t;

  typedef enum logic [2:0] {
    SC_PROBE_GO, SC_PROBE_WAIT, SC_GO, SC_WAIT, SC_HOLD
  } scan_t;
endpackage

// File: rtl/sprom_access.sv
// One read access on the three-wire serial memory: deselect, command and
// address out, 16 data bits in, deselect.
module sprom_access
  import eeld_pkg::*;
#(
  parameter int HALF_CLKS = 50,
  parameter int NARROW_AW = 6,
  parameter int WIDE_AW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               wide,
  input  logic [WIDE_AW-1:0] addr,
  output logic               done,
  output logic [WORD_W-1:0]  word,
  output logic               cs,
  output logic               sk,
  output logic               di,
  input  logic               so_in
);
  localparam int CMDW = OPW + WIDE_AW;
  localparam int TW   = $clog2(HALF_CLKS + 1);
  localparam int BW   = $clog2(CMDW);
  localparam int DCW  = $clog2(WORD_W + 1);
  localparam logic [TW-1:0]  RELOAD = TW'(HALF_CLKS - 1);
  localparam logic [BW-1:0]  LAST_W = BW'(CMDW - 1);
  localparam logic [BW-1:0]  LAST_N = BW'(OPW + NARROW_AW - 1);
  localparam logic [DCW-1:0] NBITS  = DCW'(WORD_W);

  phase_t            ph;
  logic [TW-1:0]     tmr;
  logic              tick;
  logic [CMDW-1:0]   cmd_sr;
  logic [BW-1:0]     bits;
  logic [DCW-1:0]    dcnt;
  logic [WORD_W-1:0] shf;
  logic [1:0]        sync;

  assign tick = (tmr == '0);

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], so_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; tmr <= '0; cs <= 1'b0; sk <= 1'b0; di <= 1'b0;
      cmd_sr <= '0; bits <= '0; dcnt <= '0; shf <= '0; word <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ph != PH_IDLE) tmr <= tick ? RELOAD : tmr - 1'b1;
      case (ph)
        PH_IDLE: if (start) begin
          cmd_sr <= wide ? {READ_OP, addr}
                         : {READ_OP, addr[NARROW_AW-1:0], {(WIDE_AW-NARROW_AW){1'b0}}};
          bits   <= wide ? LAST_W : LAST_N;
          tmr    <= RELOAD;
          cs <= 1'b0; sk <= 1'b0; di <= 1'b0;
          ph <= PH_DESEL;
        end
        PH_DESEL: if (tick) begin
          cs <= 1'b1; di <= cmd_sr[CMDW-1]; ph <= PH_CLO;
        end
        PH_CLO: if (tick) begin
          sk <= 1'b1; ph <= PH_CHI;
        end
        PH_CHI: if (tick) begin
          sk <= 1'b0;
          if (bits == '0) begin
            di <= 1'b0; dcnt <= NBITS; ph <= PH_DLO;
          end else begin
            cmd_sr <= cmd_sr << 1;
            di     <= cmd_sr[CMDW-2];
            bits   <= bits - 1'b1;
            ph     <= PH_CLO;
          end
        end
        PH_DLO: if (tick) begin
          if (dcnt == '0) begin
            cs <= 1'b0; ph <= PH_END;
          end else begin
            sk <= 1'b1; ph <= PH_DHI;
          end
        end
        PH_DHI: if (tick) begin
          shf  <= {shf[WORD_W-2:0], sync[1]};
          dcnt <= dcnt - 1'b1;
          sk   <= 1'b0;
          ph   <= PH_DLO;
        end
        PH_END: if (tick) begin
          word <= shf; done <= 1'b1; ph <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // data-in may only move while the shift clock is low
  assert_di_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (sk && $past(sk)) |-> $stable(di));
  // the clock never pulses with the device deselected
  assert_sk_in_cs_R3: assert property (@(posedge clk) disable iff (rst)
    sk |-> cs);
endmodule

// File: rtl/image_scanner.sv
// Sequences the trial read and the 64 image reads, sums and captures.
module image_scanner
  import eeld_pkg::*;
#(
  parameter int              WORDS     = 64,
  parameter logic [WORD_W-1:0] SIGNATURE = 16'hBABA,
  parameter int              WIDE_AW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 rd_start,
  output logic                 rd_wide,
  output logic [WIDE_AW-1:0]   rd_addr,
  input  logic                 rd_done,
  input  logic [WORD_W-1:0]    rd_word,
  output logic [STATION_W-1:0] station_addr,
  output logic                 addr_valid,
  output logic                 load_done
);
  localparam int IW = $clog2(WORDS);
  localparam int AW = $clog2(WORDS + 2);
  localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);
  localparam logic [IW-1:0] CAP_LIM  = IW'(ADDR_WORDS);

  scan_t              st;
  logic [IW-1:0]      idx;
  logic [WORD_W-1:0]  sum, sum_next;
  logic [STATION_W-1:0] cap;
  logic [AW-1:0]      acc_cnt;

  assign sum_next = sum + rd_word;
  assign rd_addr  = WIDE_AW'(idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SC_PROBE_GO; idx <= '0; sum <= '0; cap <= '0;
      rd_start <= 1'b0; rd_wide <= 1'b0;
      station_addr <= '0; addr_valid <= 1'b0; load_done <= 1'b0;
    end else begin
      rd_start  <= 1'b0;
      load_done <= 1'b0;
      case (st)
        SC_PROBE_GO: begin
          rd_start <= 1'b1; rd_wide <= 1'b0; idx <= '0; st <= SC_PROBE_WAIT;
        end
        SC_PROBE_WAIT: if (rd_done) begin
          rd_wide <= (rd_word == '1);
          st <= SC_GO;
        end
        SC_GO: begin
          rd_start <= 1'b1; st <= SC_WAIT;
        end
        SC_WAIT: if (rd_done) begin
          sum <= sum_next;
          if (idx < CAP_LIM)
            cap <= {cap[STATION_W-WORD_W-1:0], rd_word[7:0], rd_word[15:8]};
          if (idx == LAST_IDX) begin
            addr_valid   <= (sum_next == SIGNATURE);
            station_addr <= (sum_next == SIGNATURE) ? cap : '0;
            load_done    <= 1'b1;
            st <= SC_HOLD;
          end else begin
            idx <= idx + 1'b1;
            st  <= SC_GO;
          end
        end
        default: st <= SC_HOLD;
      endcase
    end
  end

  // checker: accesses completed since reset
  always_ff @(posedge clk) begin
    if (rst) acc_cnt <= '0;
    else if (rd_done) acc_cnt <= acc_cnt + 1'b1;
  end

  assert_access_count_R5: assert property (@(posedge clk) disable iff (rst)
    load_done |-> (acc_cnt == AW'(WORDS + 1)));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    load_done |=> !load_done);
  assert_zero_when_bad_R7: assert property (@(posedge clk) disable iff (rst)
    (load_done && !addr_valid) |-> (station_addr == '0));
endmodule

// File: rtl/eeprom_addr_loader.sv
module eeprom_addr_loader
  import eeld_pkg::*;
#(
  parameter int                HALF_CLKS = 50,
  parameter int                WORDS     = 64,
  parameter logic [WORD_W-1:0] SIGNATURE = 16'hBABA,
  parameter int                NARROW_AW = 6,
  parameter int                WIDE_AW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 rom_cs,
  output logic                 rom_sk,
  output logic                 rom_di,
  input  logic                 rom_do,
  output logic [STATION_W-1:0] station_addr,
  output logic                 addr_valid,
  output logic                 load_done
);
  logic               rd_start, rd_wide, rd_done;
  logic [WIDE_AW-1:0] rd_addr;
  logic [WORD_W-1:0]  rd_word;

  image_scanner #(.WORDS(WORDS), .SIGNATURE(SIGNATURE), .WIDE_AW(WIDE_AW)) u_scan (
    .clk(clk), .rst(rst), .rd_start(rd_start), .rd_wide(rd_wide),
    .rd_addr(rd_addr), .rd_done(rd_done), .rd_word(rd_word),
    .station_addr(station_addr), .addr_valid(addr_valid), .load_done(load_done));

  sprom_access #(.HALF_CLKS(HALF_CLKS), .NARROW_AW(NARROW_AW), .WIDE_AW(WIDE_AW)) u_port (
    .clk(clk), .rst(rst), .start(rd_start), .wide(rd_wide), .addr(rd_addr),
    .done(rd_done), .word(rd_word), .cs(rom_cs), .sk(rom_sk), .di(rom_di),
    .so_in(rom_do));

  // checker: length of the current shift-clock level, saturating
  localparam int RW = $clog2(HALF_CLKS + 1);
  localparam logic [RW-1:0] RSAT = RW'(HALF_CLKS);
  logic          sk_d, finished;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sk_d <= 1'b0; run <= RSAT; finished <= 1'b0;
    end else begin
      sk_d <= rom_sk;
      if (rom_sk != sk_d) run <= RW'(1);
      else if (run != RSAT) run <= run + 1'b1;
      if (load_done) finished <= 1'b1;
    end
  end

  assert_half_width_R8: assert property (@(posedge clk) disable iff (rst)
    (rom_sk != sk_d) |-> (run == RSAT));
  assert_quiet_after_R9: assert property (@(posedge clk) disable iff (rst)
    finished |-> !rom_cs);
endmodule

// File: tb/eeprom_addr_loader_tb.sv
module eeprom_addr_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rom_cs, rom_sk, rom_di, rom_do;
  logic [47:0] station_addr;
  logic addr_valid, load_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_addr_loader #(.HALF_CLKS(HALF)) u_dut (
    .clk(clk), .rst(rst), .rom_cs(rom_cs), .rom_sk(rom_sk), .rom_di(rom_di),
    .rom_do(rom_do), .station_addr(station_addr), .addr_valid(addr_valid),
    .load_done(load_done));

  // {wide device, bad checksum, word0, word1, word2}
  localparam logic [49:0] CASES [4] = '{
    {1'b0, 1'b0, 16'h1200, 16'h5634, 16'h9A78},
    {1'b1, 1'b0, 16'hFFFD, 16'h0102, 16'h0304},
    {1'b0, 1'b1, 16'hA0B0, 16'hC0D0, 16'hE0F0},
    {1'b1, 1'b1, 16'hFFFC, 16'h1111, 16'h2222}
  };

  int nchk = 0, nbad = 0;
  bit reported = 0;

  // behavioural memory, sampled on the falling system clock edge
  logic [15:0] mem [0:255];
  int dev_aw = 6;
  int acc, ncmd, dcnt, cmdv, rad, op_err, adr_err, glitch, width_err, run;
  bit in_data, p_cs, p_sk, p_di;

  always @(negedge clk) begin
    if (rst) begin
      acc = 0; ncmd = 0; dcnt = 0; cmdv = 0; rad = 0; in_data = 0;
      op_err = 0; adr_err = 0; glitch = 0; width_err = 0; run = 1000;
      p_cs = 0; p_sk = 0; p_di = 0;
      rom_do <= 1'b1;
    end else begin
      if (rom_cs && !p_cs) begin
        acc++; ncmd = 0; cmdv = 0; in_data = 0; rom_do <= 1'b1;
      end
      if (rom_sk != p_sk) begin
        if (run < HALF) width_err++;
        run = 1;
      end else if (run < 1000) run++;
      if (rom_cs && rom_sk && p_sk && (rom_di != p_di)) glitch++;
      if (rom_cs && rom_sk && !p_sk) begin
        if (!in_data) begin
          cmdv = (cmdv << 1) | int'(rom_di);
          ncmd++;
          if (ncmd == 3 + dev_aw) begin
            in_data = 1; dcnt = 0;
            rad = cmdv & ((1 << dev_aw) - 1);
            if (((cmdv >> dev_aw) & 7) != 6) op_err++;
            if (rad != ((acc == 1) ? 0 : acc - 2)) adr_err++;
          end
        end else begin
          rom_do <= (dcnt < 16) ? mem[rad][15 - dcnt] : 1'b1;
          dcnt++;
        end
      end
      if (!rom_cs) rom_do <= 1'b1;
      p_cs = rom_cs; p_sk = rom_sk; p_di = rom_di;
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
    end
  endtask

  task automatic build_image(logic [49:0] e);
    logic [15:0] s;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0] = e[47:32]; mem[1] = e[31:16]; mem[2] = e[15:0];
    for (int i = 3; i < 63; i++) mem[i] = 16'(i * 16'h0123) ^ 16'h5A5A;
    s = 16'h0;
    for (int i = 0; i < 63; i++) s = s + mem[i];
    mem[63] = 16'hBABA - s + {15'd0, e[48]};
    dev_aw = e[49] ? 8 : 6;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      logic [49:0] e;
      logic [47:0] exp_addr;
      int t, acc_seen;
      e = CASES[c];
      build_image(e);
      exp_addr = e[48] ? 48'h0 :
        {e[39:32], e[47:40], e[23:16], e[31:24], e[7:0], e[15:8]};
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state, also after a previous valid load
      check("R1", "addr in reset", {16'h0, station_addr}, 64'h0);
      check("R1", "valid/done/cs/sk in reset",
            {60'h0, addr_valid, load_done, rom_cs, rom_sk}, 64'h0);
      rst = 1'b0;
      @(negedge clk);
      check("R1", "outputs after release",
            {15'h0, station_addr, addr_valid, load_done}, 64'h0);
      t = 0;
      while (!load_done && t < 40000) begin @(negedge clk); t++; end
      check("R9", "done seen", {63'h0, load_done}, 64'h1);
      check("R6", "valid flag", {63'h0, addr_valid}, {63'h0, !e[48]});
      check("R7", "station address", {16'h0, station_addr}, {16'h0, exp_addr});
      check("R5", "access count", 64'(acc), 64'd65);
      check("R4", "word addresses seen by device", 64'(adr_err), 64'd0);
      check("R2", "read opcode", 64'(op_err), 64'd0);
      check("R2", "data-in change while clock high", 64'(glitch), 64'd0);
      check("R8", "short clock level", 64'(width_err), 64'd0);
      @(negedge clk);
      check("R9", "done one cycle", {63'h0, load_done}, 64'h0);
      check("R3", "chip select low at end", {63'h0, rom_cs}, 64'h0);
      acc_seen = acc;
      repeat (300) begin
        @(negedge clk);
        if (load_done || rom_cs) break;
      end
      check("R9", "no access after done", 64'(acc), 64'(acc_seen));
      check("R9", "done stays low", {63'h0, load_done}, 64'h0);
      check("R9", "outputs hold",
            {15'h0, station_addr, addr_valid}, {15'h0, exp_addr, !e[48]});
    end
    summary();
    $finish;
  end
endmodule